// File: doc/BRIEF.md
# Chip ID key reader

This block is a small register-mapped peripheral that exposes a fixed 128-bit device identifier, four bytes at a time. The identifier arrives on a wide input port that stays constant during operation. Software reaches the block through a simple 32-bit register bus inside a 1 KiB address window.

To read part of the identifier, software writes a control word. The upper half of that word is a byte offset. The word also carries a trigger bit and a lock pattern. When the trigger and at least one lock bit are both set, and the offset leaves all four bytes inside the identifier, the block copies a big-endian 4-byte slice of the identifier into the key register. Software then reads the key register.

The trigger bit never stays set in the stored control word. Every access is a single full 32-bit access.

The write path is a decoder whose selection is an enumerated type with three values:
- `SEL_NONE`: unmapped offset.
- `SEL_CTRL`: control register, offset 0x40.
- `SEL_KEY`: key register, offset 0x60.

On each write, the key register takes one of two named transitions:
- `KEY_HOLD`: the key keeps its value.
- `KEY_LOAD`: the key takes the selected slice on the next clock edge.

Top module: `chip_id_key_reader`

## Requirements
- R1: After reset, reads of the control register (offset 0x40) and of the key register (offset 0x60) both return 0.
- R2: A write to offset 0x40 stores the whole written word, except that bit 1 is stored as 0. A read of 0x40 returns that value.
- R3: A control write loads the key register on the clock edge that takes the write when all three of these hold: bit 1 is set, at least one bit of the mask 0xAC00 is set, and the byte offset in bits 31:16 is at most 12.
- R4: The loaded key is big-endian. Identifier byte n sits in identifier bits 127-8n down to 120-8n. The byte at the offset goes to key bits 31:24, and the next three bytes fill bits 23:16, 15:8 and 7:0 in that order.
- R5: A triggered, locked control write with a byte offset above 12 leaves the key register unchanged.
- R6: A control write that has bit 1 set but no bit of the mask 0xAC00, or that has lock bits but bit 1 clear, leaves the key register unchanged.
- R7: Writes to offset 0x60 have no effect on the key register.
- R8: Reads of any offset other than 0x40 and 0x60 return 0. Writes to those offsets change neither register.
- R9: While read enable is low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address within the 1 KiB window |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read enable |
| bus_rd_data | output | 32 | Read data, combinational from the register contents |
| id_value | input | 128 | Device identifier, byte 0 in bits 127:120 |

## Verification
The offset is swept over every value from 0 to 20 with two different identifiers: one with incrementing bytes and one with scrambled bytes. Incrementing bytes show whether the byte order and the starting byte are right. Scrambled bytes catch a slice that only matches the pattern by accident.

Each lock-mask bit is tried on its own, together with the trigger. Writes are also made with the trigger alone and with the lock bits alone, which tells the gating conditions apart. Offsets 13 and above check the bound at its edge.

Writes to the key register and to unmapped addresses are each followed by a read-back of both registers. A read with read enable low is also checked.

// File: rtl/cidk_pkg.sv
package cidk_pkg;
    localparam int unsigned ADDR_W    = 10;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ID_BYTES  = 16;
    localparam int unsigned ID_W      = ID_BYTES * 8;
    localparam int unsigned WORD_B    = DATA_W / 8;
    localparam int unsigned MAX_OFS   = ID_BYTES - WORD_B;
    localparam int unsigned OFS_LSB   = 16;
    localparam int unsigned OFS_W     = DATA_W - OFS_LSB;
    localparam int unsigned TRIG_BIT  = 1;
    localparam logic [DATA_W-1:0] LOCK_MASK = 32'h0000_AC00;
    localparam logic [ADDR_W-1:0] CTRL_OFS  = 10'h040;
    localparam logic [ADDR_W-1:0] KEY_OFS   = 10'h060;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_KEY  = 2'd2
    } reg_sel_e;

    typedef enum logic {
        KEY_HOLD = 1'b0,
        KEY_LOAD = 1'b1
    } key_next_e;
endpackage

// File: rtl/cidk_addr_decode.sv
module cidk_addr_decode
    import cidk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == CTRL_OFS) begin
            sel = SEL_CTRL;
        end else if (addr == KEY_OFS) begin
            sel = SEL_KEY;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/cidk_slice_extract.sv
module cidk_slice_extract
    import cidk_pkg::*;
(
    input  logic [ID_W-1:0]   id_value,
    input  logic [OFS_W-1:0]  byte_ofs,
    output logic [DATA_W-1:0] slice,
    output logic              in_range
);
    localparam int unsigned IDX_W = $clog2(ID_BYTES);

    logic [7:0] id_bytes [ID_BYTES];

    for (genvar b = 0; b < ID_BYTES; b++) begin : g_bytes
        assign id_bytes[b] = id_value[ID_W-1-8*b -: 8];
    end

    assign in_range = (byte_ofs <= OFS_W'(MAX_OFS));

    for (genvar k = 0; k < WORD_B; k++) begin : g_lanes
        logic [IDX_W-1:0] idx;
        assign idx = byte_ofs[IDX_W-1:0] + IDX_W'(k);
        assign slice[DATA_W-1-8*k -: 8] = id_bytes[idx];
    end
endmodule

// File: rtl/cidk_regs.sv
module cidk_regs
    import cidk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] slice,
    input  logic              in_range,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] key_q
);
    key_next_e     key_next;
    logic [DATA_W-1:0] ctrl_d;
    logic          ctrl_we;

    always_comb begin
        key_next = KEY_HOLD;
        ctrl_we  = 1'b0;
        ctrl_d   = wr_data;
        ctrl_d[TRIG_BIT] = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    ctrl_we = 1'b1;
                    if (wr_data[TRIG_BIT] && ((wr_data & LOCK_MASK) != '0) && in_range) begin
                        key_next = KEY_LOAD;
                    end
                end
                SEL_KEY:  key_next = KEY_HOLD;
                SEL_NONE: key_next = KEY_HOLD;
                default:  key_next = KEY_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else begin
            unique case (key_next)
                KEY_LOAD: key_q <= slice;
                KEY_HOLD: key_q <= key_q;
                default:  key_q <= key_q;
            endcase
        end
    end

    // R7
    key_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_KEY) |=> $stable(key_q));

    // R5
    ofs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL && wr_data[DATA_W-1:OFS_LSB] > OFS_W'(MAX_OFS)) |=> $stable(key_q));

    // R6
    no_trigger_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL && !wr_data[TRIG_BIT]) |=> $stable(key_q));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(key_q) && $stable(ctrl_q)));
endmodule

// File: rtl/chip_id_key_reader.sv
module chip_id_key_reader
    import cidk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wr_data,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rd_data,
    input  logic [127:0]      id_value
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] slice;
    logic              in_range;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] key_q;

    cidk_addr_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    cidk_slice_extract u_slice (
        .id_value (id_value),
        .byte_ofs (bus_wr_data[DATA_W-1:OFS_LSB]),
        .slice    (slice),
        .in_range (in_range)
    );

    cidk_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .sel      (sel),
        .wr_data  (bus_wr_data),
        .slice    (slice),
        .in_range (in_range),
        .ctrl_q   (ctrl_q),
        .key_q    (key_q)
    );

    always_comb begin
        bus_rd_data = '0;
        if (bus_rd_en) begin
            unique case (sel)
                SEL_CTRL: bus_rd_data = ctrl_q;
                SEL_KEY:  bus_rd_data = key_q;
                SEL_NONE: bus_rd_data = '0;
                default:  bus_rd_data = '0;
            endcase
        end
    end

    // R2
    ctrl_trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == CTRL_OFS) |-> (bus_rd_data[TRIG_BIT] == 1'b0));

    // R9
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |-> (bus_rd_data == '0));

    // R4
    first_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == CTRL_OFS && bus_wr_data[TRIG_BIT] && bus_wr_data[15]
         && bus_wr_data[31:16] == 16'd0)
        |=> (key_q == $past(id_value[127:96])));
endmodule

// File: tb/test_chip_id_key_reader.sv
`timescale 1ns/1ps
module test_chip_id_key_reader;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [9:0]   bus_addr = '0;
    logic         bus_wr_en = 1'b0;
    logic [31:0]  bus_wr_data = '0;
    logic         bus_rd_en = 1'b0;
    logic [31:0]  bus_rd_data;
    logic [127:0] id_value = '0;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] m_ctrl;
    logic [31:0] m_key;

    always #4 clk = ~clk;

    chip_id_key_reader i_chip_id_key_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_en   (bus_rd_en),
        .bus_rd_data (bus_rd_data),
        .id_value    (id_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wr_data = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd_en = 1'b1;
        #1;
        d = bus_rd_data;
        bus_rd_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_slice(input logic [127:0] id, input int ofs);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            r[31-8*k -: 8] = id[127-8*(ofs+k) -: 8];
        end
        return r;
    endfunction

    task automatic ctrl_write_model(input logic [31:0] d);
        int ofs;
        ofs = int'(d[31:16]);
        bus_write(10'h040, d);
        m_ctrl = d & ~32'h2;
        if (d[1] && ((d & 32'hAC00) != 0) && ofs <= 12) begin
            m_key = exp_slice(id_value, ofs);
        end
    endtask

    task automatic check_both(input string req);
        logic [31:0] v;
        bus_read(10'h040, v);
        check(req, v, m_ctrl);
        bus_read(10'h060, v);
        check(req, v, m_key);
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] locks [4];
        locks[0] = 16'h8000;
        locks[1] = 16'h2000;
        locks[2] = 16'h0800;
        locks[3] = 16'h0400;
        m_ctrl = '0;
        m_key = '0;
        for (int b = 0; b < 16; b++) id_value[127-8*b -: 8] = 8'(b + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_both("R1");

        // R9 read enable low gives zero
        @(negedge clk);
        bus_addr = 10'h040;
        bus_wr_data = '0;
        #1;
        check("R9", bus_rd_data, 32'h0);

        // R2 control store with trigger cleared
        ctrl_write_model(32'h1234_56F3);
        check_both("R2");
        ctrl_write_model(32'hFFFF_53FF);
        check_both("R2");

        for (int pat = 0; pat < 2; pat++) begin
            if (pat == 1) begin
                for (int b = 0; b < 16; b++) id_value[127-8*b -: 8] = 8'((b * 37 + 91) ^ 8'h5A);
            end
            // R3 R4 R5 sweep offsets and lock bits
            for (int ofs = 0; ofs <= 20; ofs++) begin
                for (int l = 0; l < 4; l++) begin
                    ctrl_write_model({16'(ofs), locks[(l + ofs) % 4] | 16'h0002});
                    bus_read(10'h060, v);
                    check(ofs <= 12 ? "R3/R4 fetch" : "R5 out of range", v, m_key);
                end
            end
        end

        // R6 trigger without lock, lock without trigger
        ctrl_write_model({16'd3, 16'h8400});
        ctrl_write_model({16'd0, 16'h0002});
        check_both("R6 trigger only");
        ctrl_write_model({16'd5, 16'hAC00});
        check_both("R6 lock only");
        ctrl_write_model({16'd7, 16'h53FD});
        check_both("R6 non-lock bits");

        // R7 key writes ignored
        bus_write(10'h060, 32'hDEAD_BEEF);
        check_both("R7");

        // R8 unmapped addresses
        for (int a = 0; a < 1024; a += 52) begin
            if (a != 'h40 && a != 'h60) begin
                bus_write(10'(a), 32'h0000_AC02);
                bus_read(10'(a), v);
                check("R8 read zero", v, 32'h0);
            end
        end
        bus_write(10'h044, 32'h0000_AC02);
        check_both("R8 write ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule